// File: doc/BRIEF.md
# FSK Caller-ID Transmit Sequencer

This block turns a host-loaded byte buffer into the bit stream of a caller-ID style FSK burst. A start command launches three sections in a fixed order. The first is a seizure run of alternating bits. The second is a run of mark bits. The third is the buffered bytes, sent as asynchronous characters. Each bit is held for one baud interval. A downstream tone oscillator receives the bit as a 2-bit tone code, together with a flag that says when the line is live rather than muted.

The host drives a control write strobe. Each write carries four bits: an enable bit, a convention select (0 for the North-American tone pair, 1 for the UK pair), a mark-after-send select and a start bit. The three section lengths sit on plain inputs and are captured at launch. The start flag reads back as busy and drops by itself when the burst ends. With mark-after-send set, the line then stays live sending marks until the host cancels the tail.

The output is a paced stream. `tx_valid` high means the current `tx_bit`/`tx_freq` are to be transmitted. There is no ready input, so the consumer cannot apply back-pressure and must accept the code on every cycle it is valid. Symbols change only at baud boundaries.

Top module: `fsk_cid_seq`

## Requirements
- R1: After reset `tx_valid` and `start_flag` are 0, and the tone select is North-American.
- R2: A control write with enable=1 and start=1, issued while no burst is running, raises `start_flag` on the next cycle and starts the burst. The one exception is a cancel write during a tail (R9). The seizure section comes first: `seize_len` bits alternating 0,1,0,… starting with 0.
- R3: Next comes `mark_len` bits of 1. A section of length 0 is skipped.
- R4: Next comes `min(data_len, DEPTH)` bytes from buffer addresses 0 upward. Each byte is sent as a 0 start bit, then its 8 data bits LSB first, then a 1 stop bit.
- R5: The first bit appears on the cycle after the launching write. Every bit is held for exactly `CLK_DIV` cycles.
- R6: When the last bit has been held, `start_flag` drops. With mark-after-send=0, `tx_valid` drops in the same cycle.
- R7: If all three lengths are 0, `start_flag` is high for exactly one cycle and `tx_valid` stays 0.
- R8: With mark-after-send=1 at the end of the burst, `tx_valid` stays 1 with `tx_bit`=1 indefinitely and `start_flag` stays 0.
- R9: During a tail, a write with start=1 and mark-after-send=0 mutes the line on the next cycle. A write with start=0 does not stop the tail. A write with start=1 and mark-after-send=1 launches a new burst.
- R10: `tx_freq` = {convention, bit}: 00 = 2200 Hz space, 01 = 1200 Hz mark (North-American); 10 = 2100 Hz space, 11 = 1300 Hz mark (UK). The convention takes the value of the latest control write.
- R11: A control write with enable=0 aborts any burst or tail. On the next cycle `tx_valid` and `start_flag` are 0. A start carried by such a write is ignored.
- R12: While a burst runs, buffer writes and start writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Enable bit of the write |
| ctrl_uk | input | 1 | Convention select: 0 North-American, 1 UK |
| ctrl_mas | input | 1 | Mark-after-send select |
| ctrl_start | input | 1 | Start bit of the write |
| seize_len | input | LEN_W | Seizure section length in bits |
| mark_len | input | LEN_W | Mark section length in bits |
| data_len | input | $clog2(DEPTH+1) | Byte count, clamped to DEPTH |
| ram_we | input | 1 | Buffer write enable |
| ram_addr | input | $clog2(DEPTH) | Buffer write address |
| ram_wdata | input | 8 | Buffer write byte |
| tx_valid | output | 1 | Line live (not muted) |
| tx_bit | output | 1 | Current bit, 1 = mark |
| tx_freq | output | 2 | Tone code for the oscillator |
| start_flag | output | 1 | Start bit readback, self-clearing |

## Verification
The assertions cover the per-cycle rules. Launch raises the flag. No symbol changes between baud ticks while a burst runs. A tail only sends marks. A lone flag with a muted line drops next cycle. Abort and cancel writes mute the line at once. The section order, the LSB-first framing, the length clamp, the ignored buffer writes and the tone codes per convention depend on buffer contents and history. They are shown only by the bench's reference model, which rebuilds the expected bit list at each launch and compares every cycle.

// File: rtl/fsk_cid_pkg.sv
package fsk_cid_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SEIZE = 3'd1,
    PH_MARK  = 3'd2,
    PH_DATA  = 3'd3,
    PH_TAIL  = 3'd4
  } phase_t;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned STOP_POS = BYTE_W + 1;
endpackage

// File: rtl/fsk_baud_gen.sv
module fsk_baud_gen #(
  parameter int unsigned CLK_DIV = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/fsk_byte_ram.sv
module fsk_byte_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fsk_seq_fsm.sv
module fsk_seq_fsm
  import fsk_cid_pkg::*;
#(
  parameter int unsigned LEN_W = 9,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DLW   = 7,
  parameter int unsigned AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ctrl_en,
  input  logic             ctrl_uk,
  input  logic             ctrl_mas,
  input  logic             ctrl_start,
  input  logic [LEN_W-1:0] seize_len,
  input  logic [LEN_W-1:0] mark_len,
  input  logic [DLW-1:0]   data_len,
  input  logic             tick,
  input  logic [7:0]       rdata,
  output logic [AW-1:0]    raddr,
  output logic             launch,
  output logic             active,
  output logic             cfg_uk,
  output logic             tx_valid,
  output logic             tx_bit,
  output logic             start_flag
);
  localparam int unsigned IW = (LEN_W > DLW) ? LEN_W : DLW;

  phase_t         phase, phase_n;
  logic [IW-1:0]  idx, idx_n;
  logic [3:0]     bpos, bpos_n;
  logic [IW-1:0]  lat_s, lat_m, lat_d;
  logic [IW-1:0]  s_in, m_in, d_in;
  logic           cfg_mas, tail, abort, cancel;

  function automatic phase_t pick_phase(input phase_t from, input logic [IW-1:0] s,
                                        input logic [IW-1:0] m, input logic [IW-1:0] d,
                                        input logic end_mas);
    if (from == PH_SEIZE && s != '0) return PH_SEIZE;
    if ((from == PH_SEIZE || from == PH_MARK) && m != '0) return PH_MARK;
    if (from != PH_TAIL && d != '0) return PH_DATA;
    return end_mas ? PH_TAIL : PH_IDLE;
  endfunction

  function automatic logic is_active(input phase_t p);
    return (p == PH_SEIZE) || (p == PH_MARK) || (p == PH_DATA);
  endfunction

  assign s_in = IW'(seize_len);
  assign m_in = IW'(mark_len);
  assign d_in = (data_len > DLW'(DEPTH)) ? IW'(DEPTH) : IW'(data_len);

  assign active = is_active(phase);
  assign tail   = (phase == PH_TAIL);
  assign abort  = ctrl_wr && !ctrl_en;
  assign cancel = ctrl_wr && ctrl_en && ctrl_start && tail && !ctrl_mas;
  assign launch = ctrl_wr && ctrl_en && ctrl_start && !active && !cancel;

  always_comb begin
    phase_n = phase;
    idx_n   = idx;
    bpos_n  = bpos;
    if (abort || cancel) begin
      phase_n = PH_IDLE;
      idx_n   = '0;
      bpos_n  = '0;
    end else if (launch) begin
      phase_n = pick_phase(PH_SEIZE, s_in, m_in, d_in, 1'b0);
      idx_n   = '0;
      bpos_n  = '0;
    end else if (tick) begin
      unique case (phase)
        PH_SEIZE: begin
          if (idx == lat_s - 1'b1) begin
            phase_n = pick_phase(PH_MARK, lat_s, lat_m, lat_d, cfg_mas);
            idx_n   = '0;
          end else idx_n = idx + 1'b1;
        end
        PH_MARK: begin
          if (idx == lat_m - 1'b1) begin
            phase_n = pick_phase(PH_DATA, lat_s, lat_m, lat_d, cfg_mas);
            idx_n   = '0;
          end else idx_n = idx + 1'b1;
        end
        PH_DATA: begin
          if (bpos == 4'(STOP_POS)) begin
            bpos_n = '0;
            if (idx == lat_d - 1'b1) begin
              phase_n = pick_phase(PH_TAIL, lat_s, lat_m, lat_d, cfg_mas);
              idx_n   = '0;
            end else idx_n = idx + 1'b1;
          end else bpos_n = bpos + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      idx        <= '0;
      bpos       <= '0;
      lat_s      <= '0;
      lat_m      <= '0;
      lat_d      <= '0;
      cfg_uk     <= 1'b0;
      cfg_mas    <= 1'b0;
      start_flag <= 1'b0;
    end else begin
      phase      <= phase_n;
      idx        <= idx_n;
      bpos       <= bpos_n;
      start_flag <= launch || is_active(phase_n);
      if (ctrl_wr) begin
        cfg_uk  <= ctrl_uk;
        cfg_mas <= ctrl_mas;
      end
      if (launch) begin
        lat_s <= s_in;
        lat_m <= m_in;
        lat_d <= d_in;
      end
    end
  end

  always_comb begin
    unique case (phase)
      PH_SEIZE: tx_bit = idx[0];
      PH_DATA: begin
        if (bpos == 4'd0)                 tx_bit = 1'b0;
        else if (bpos == 4'(STOP_POS))    tx_bit = 1'b1;
        else                              tx_bit = rdata[3'(bpos - 4'd1)];
      end
      default:  tx_bit = 1'b1;
    endcase
  end

  assign tx_valid = (phase != PH_IDLE);
  assign raddr    = idx[AW-1:0];
endmodule

// File: rtl/fsk_cid_seq.sv
module fsk_cid_seq #(
  parameter int unsigned CLK_DIV = 20000,
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned LEN_W   = 9,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned DLW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ctrl_en,
  input  logic             ctrl_uk,
  input  logic             ctrl_mas,
  input  logic             ctrl_start,
  input  logic [LEN_W-1:0] seize_len,
  input  logic [LEN_W-1:0] mark_len,
  input  logic [DLW-1:0]   data_len,
  input  logic             ram_we,
  input  logic [AW-1:0]    ram_addr,
  input  logic [7:0]       ram_wdata,
  output logic             tx_valid,
  output logic             tx_bit,
  output logic [1:0]       tx_freq,
  output logic             start_flag
);
  logic          baud_tick, launch, active, cfg_uk;
  logic [AW-1:0] raddr;
  logic [7:0]    rdata;

  fsk_baud_gen #(.CLK_DIV(CLK_DIV)) u_baud (
    .clk(clk), .rst_n(rst_n), .restart(launch), .tick(baud_tick)
  );

  fsk_byte_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we && !active), .waddr(ram_addr), .wdata(ram_wdata),
    .raddr(raddr), .rdata(rdata)
  );

  fsk_seq_fsm #(.LEN_W(LEN_W), .DEPTH(DEPTH), .DLW(DLW), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en), .ctrl_uk(ctrl_uk),
    .ctrl_mas(ctrl_mas), .ctrl_start(ctrl_start),
    .seize_len(seize_len), .mark_len(mark_len), .data_len(data_len),
    .tick(baud_tick), .rdata(rdata), .raddr(raddr),
    .launch(launch), .active(active), .cfg_uk(cfg_uk),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .start_flag(start_flag)
  );

  assign tx_freq = {cfg_uk, tx_bit};
endmodule

// File: rtl/fsk_cid_chk.sv
module fsk_cid_chk (
  input logic clk,
  input logic rst_n,
  input logic ctrl_wr,
  input logic ctrl_en,
  input logic ctrl_mas,
  input logic ctrl_start,
  input logic tick,
  input logic tx_valid,
  input logic tx_bit,
  input logic start_flag
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tx_valid && !start_flag));

  a_r2_launch_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_en && ctrl_start && !start_flag && !(tx_valid && !ctrl_mas))
    |=> start_flag);

  a_r5_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_flag) && start_flag && !$past(tick)) |-> $stable(tx_bit));

  a_r7_lone_flag_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (start_flag && !tx_valid && !ctrl_wr) |=> !start_flag);

  a_r8_tail_is_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !start_flag) |-> tx_bit);

  a_r9_cancel_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_en && ctrl_start && !ctrl_mas && tx_valid && !start_flag)
    |=> !tx_valid);

  a_r11_abort_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_en) |=> (!tx_valid && !start_flag));
endmodule

bind fsk_cid_seq fsk_cid_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
  .ctrl_mas(ctrl_mas), .ctrl_start(ctrl_start), .tick(baud_tick),
  .tx_valid(tx_valid), .tx_bit(tx_bit), .start_flag(start_flag)
);

// File: tb/sim_fsk_cid_seq.sv
module sim_fsk_cid_seq;
  localparam int DIV = 4;
  localparam int DEP = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_wr = 0, ctrl_en = 0, ctrl_uk = 0, ctrl_mas = 0, ctrl_start = 0;
  logic [8:0] seize_len = '0, mark_len = '0;
  logic [6:0] data_len = '0;
  logic ram_we = 0;
  logic [5:0] ram_addr = '0;
  logic [7:0] ram_wdata = '0;
  logic tx_valid, tx_bit, start_flag;
  logic [1:0] tx_freq;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  fsk_cid_seq #(.CLK_DIV(DIV), .DEPTH(DEP), .LEN_W(9)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
    .ctrl_uk(ctrl_uk), .ctrl_mas(ctrl_mas), .ctrl_start(ctrl_start),
    .seize_len(seize_len), .mark_len(mark_len), .data_len(data_len),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_freq(tx_freq), .start_flag(start_flag)
  );

  // reference model state
  bit q[$];
  int hold = 0;
  bit tail_m = 0, start_m = 0, mas_m = 0, uk_m = 0;
  logic [7:0] mref [DEP];

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete(); hold = 0; tail_m = 0; start_m = 0; mas_m = 0; uk_m = 0;
    end else begin
      bit pre_act, pre_tail, lau, can;
      pre_act  = (q.size() > 0);
      pre_tail = tail_m;
      can = ctrl_wr && ctrl_en && ctrl_start && pre_tail && !ctrl_mas;
      lau = ctrl_wr && ctrl_en && ctrl_start && !pre_act && !can;
      if (ctrl_wr && !ctrl_en) begin
        q.delete(); tail_m = 0; hold = 0;
      end else if (lau) begin
        int dl;
        q.delete(); tail_m = 0; hold = 0;
        for (int i = 0; i < seize_len; i++) q.push_back(i[0]);
        for (int i = 0; i < mark_len; i++) q.push_back(1'b1);
        dl = (data_len > DEP) ? DEP : data_len;
        for (int b = 0; b < dl; b++) begin
          q.push_back(1'b0);
          for (int k = 0; k < 8; k++) q.push_back(mref[b][k]);
          q.push_back(1'b1);
        end
      end else if (can) begin
        tail_m = 0;
      end else if (q.size() > 0) begin
        hold++;
        if (hold == DIV) begin
          hold = 0;
          void'(q.pop_front());
          if (q.size() == 0) tail_m = mas_m;
        end
      end
      if (ctrl_wr) begin mas_m = ctrl_mas; uk_m = ctrl_uk; end
      start_m = lau || (q.size() > 0);
      if (ram_we && !pre_act) mref[ram_addr] = ram_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit eb, ev;
      ev = (q.size() > 0) || tail_m;
      eb = (q.size() > 0) ? q[0] : 1'b1;
      chk(tx_valid == ev && tx_bit == eb && tx_freq == {uk_m, eb} && start_flag == start_m,
          {cur_req, " per-cycle"}, {tx_valid, tx_bit, tx_freq, start_flag},
          {ev, eb, uk_m, eb, start_m});
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic ctrl(input bit en, input bit uk, input bit mas, input bit st);
    @(negedge clk);
    ctrl_wr = 1; ctrl_en = en; ctrl_uk = uk; ctrl_mas = mas; ctrl_start = st;
    @(negedge clk);
    ctrl_wr = 0; ctrl_start = 0;
  endtask

  task automatic wram(input int a, input int d);
    @(negedge clk);
    ram_we = 1; ram_addr = 6'(a); ram_wdata = 8'(d);
    @(negedge clk);
    ram_we = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_flag_low();
    for (int i = 0; i < 20000 && start_flag; i++) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk(!tx_valid && !start_flag && tx_freq == 2'b01, "R1", {tx_valid, start_flag, tx_freq}, 4'b0001);

    // burst: seizure 6, mark 4, 3 bytes, North-American, no tail
    cur_req = "R4";
    wram(0, 8'hA5); wram(1, 8'h3C); wram(2, 8'h01); wram(3, 8'hFF);
    seize_len = 6; mark_len = 4; data_len = 3;
    cur_req = "R2";
    ctrl(1, 0, 0, 1);
    chk(start_flag && tx_valid && !tx_bit, "R2", {start_flag, tx_valid, tx_bit}, 3'b110);
    cyc(3);
    chk(tx_bit == 1'b0, "R5", tx_bit, 0);
    cyc(1);
    chk(tx_bit == 1'b1 && tx_freq == 2'b01, "R5", {tx_freq}, 2'b01);
    cur_req = "R12";
    wram(1, 8'h00);
    ctrl(1, 0, 0, 1);
    cur_req = "R3";
    cyc(30 - 8);
    chk(tx_bit == 1'b1, "R3", tx_bit, 1);
    cur_req = "R4";
    cyc(11);
    chk(tx_bit == 1'b0 && tx_freq == 2'b00, "R4", tx_freq, 2'b00);
    wait_flag_low();
    cur_req = "R6";
    chk(!start_flag && !tx_valid, "R6", {start_flag, tx_valid}, 0);

    // UK convention, no seizure, tail enabled
    cur_req = "R10";
    seize_len = 0; mark_len = 2; data_len = 2;
    ctrl(1, 1, 1, 1);
    chk(tx_freq == 2'b11, "R10", tx_freq, 2'b11);
    wait_flag_low();
    cur_req = "R8";
    cyc(12);
    chk(tx_valid && tx_bit && tx_freq == 2'b11 && !start_flag, "R8", {tx_valid, tx_freq}, 3'b111);
    cur_req = "R9";
    ctrl(1, 1, 0, 0);
    cyc(5);
    chk(tx_valid == 1'b1, "R9", tx_valid, 1);
    ctrl(1, 1, 0, 1);
    chk(!tx_valid && !start_flag, "R9", {tx_valid, start_flag}, 0);

    // all lengths zero
    cur_req = "R7";
    seize_len = 0; mark_len = 0; data_len = 0;
    ctrl(1, 0, 0, 1);
    chk(start_flag && !tx_valid, "R7", {start_flag, tx_valid}, 2'b10);
    cyc(1);
    chk(!start_flag && !tx_valid, "R7", {start_flag, tx_valid}, 0);

    // clamp: 100 requested, buffer holds 64
    cur_req = "R4";
    for (int i = 0; i < DEP; i++) wram(i, i * 37 + 5);
    data_len = 100;
    ctrl(1, 0, 0, 1);
    begin
      int n = 0;
      while (start_flag && n < 10000) begin n++; @(negedge clk); end
      chk(n == DEP * 10 * DIV, "R4", n, DEP * 10 * DIV);
    end

    // tail, relaunch from tail, then abort
    cur_req = "R2";
    seize_len = 3; mark_len = 0; data_len = 1;
    ctrl(1, 0, 1, 1);
    wait_flag_low();
    cyc(6);
    ctrl(1, 0, 1, 1);
    chk(start_flag == 1'b1, "R2", start_flag, 1);
    cyc(9);
    cur_req = "R11";
    ctrl(0, 0, 1, 1);
    chk(!tx_valid && !start_flag, "R11", {tx_valid, start_flag}, 0);
    cyc(4);
    chk(!tx_valid, "R11", tx_valid, 0);

    cyc(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule